// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Retry

This block sends bytes to a smart card over a single open-drain I/O line using the T=0 character protocol. Each character is a start bit, eight data bits sent least significant bit first, and an even parity bit. After the parity bit the line is released so that the card can pull it low to reject the character. A rejected character raises a sticky error flag and is sent again without software action. A character that is not rejected sets the transmit-end flag.

Bit timing comes from an external elementary-time-unit tick. Each tick moves the character forward by one unit. Software writes a byte into a one-deep data register. The data-register-empty flag is set again as soon as that byte is moved into the frame register at the start of a character, so the next byte can be written while the current one is still on the line. Two level interrupt outputs report the error flag and the transmit-end flag, each gated by its own enable.

Top module: `sc_t0_tx`

## Requirements
- R1: Unit numbering: unit 0 starts on the tick that begins a character, and each later tick advances one unit. Unit 0 carries the start bit (0). Units 1 to 8 carry data bits D0 to D7, in that order. Unit 9 carries parity, which is the XOR of the eight data bits, so the count of ones across data and parity is even.
- R2: `io_oe_o` is high only while a character occupies units 0 to 9 and the bit for that unit is 0. From unit 10 onwards the line is released.
- R3: Writing `wr_en_i` clears `tdre_o` and `tend_o`. On the tick that starts a character that carries new data, the held byte moves into the frame register and `tdre_o` goes to 1.
- R4: The line is sampled on the tick that ends unit 10. If the line is low there, `err_o` goes to 1. `err_o` stays at 1 until a pulse on `err_clr_i` writes it to 0.
- R5: `irq_err_o` is high exactly while `err_o` and `rie_i` are both high.
- R6: A rejected character leaves `tend_o` at 0 and is sent again with the same byte. The resend starts 13 units after the previous start bit began, which is 3 units after parity ends.
- R7: A character whose sample point reads high sets `tend_o` on that sampling tick. If another byte is waiting, it starts on the next tick, 12 units after the previous start, which is 2 units after parity ends. Otherwise the line stays released.
- R8: `irq_tend_o` is high exactly while `tend_o` and `tie_i` are both high.
- R9: While `tx_en_i` is low, no character carrying new data starts, and the byte stays pending with `tdre_o` at 0.
- R10: After reset, `tdre_o` and `tend_o` are 1, `err_o` is 0, and `io_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| etu_tick_i | input | 1 | One-cycle pulse per elementary time unit |
| tx_en_i | input | 1 | Allows new characters to start |
| rie_i | input | 1 | Error interrupt enable |
| tie_i | input | 1 | Transmit-end interrupt enable |
| wr_en_i | input | 1 | Write strobe for the data register |
| wr_data_i | input | 8 | Byte to transmit |
| err_clr_i | input | 1 | Writes 0 to the error flag |
| io_i | input | 1 | Level read back from the I/O line |
| io_oe_o | output | 1 | Pulls the I/O line low when high |
| tdre_o | output | 1 | Data register empty |
| tend_o | output | 1 | Transmit end |
| err_o | output | 1 | Error signal received |
| irq_err_o | output | 1 | Error interrupt request |
| irq_tend_o | output | 1 | Transmit-end interrupt request |

## Verification
The hardest situation to reach is a rejection that falls exactly on the single sampling tick, followed by a resend that must begin on one precise tick. The bench generates every elementary-time-unit tick itself, so it always knows the current unit. It models the card by pulling the line low only around the sampling tick of the characters it chooses to reject. It then checks each unit of the resend, so a resend that starts early or late shows up as a wrong start or data bit. Back-to-back characters, rejections with the interrupt enables off, and a second rejection with the error flag still set are reached the same way.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
  // idle units after parity before the next start bit
  localparam int unsigned GAP_OK  = 2;
  localparam int unsigned GAP_ERR = 3;

  typedef struct packed {
    logic tdre;
    logic tend;
    logic err;
  } sc_t0_stat_t;
endpackage

// File: rtl/sc_t0_seq.sv
module sc_t0_seq
  import sc_t0_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAR_U   = DATA_W + 1,
  localparam int unsigned SMP_U   = PAR_U + 1,
  localparam int unsigned END_OK  = PAR_U + GAP_OK,
  localparam int unsigned END_ERR = PAR_U + GAP_ERR,
  localparam int unsigned CNT_W   = $clog2(END_ERR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tx_en_i,
  input  logic             pend_i,
  input  logic             io_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_det_o,
  output logic             ok_det_o
);
  localparam logic [CNT_W-1:0] C_SMP     = CNT_W'(SMP_U);
  localparam logic [CNT_W-1:0] C_END_OK  = CNT_W'(END_OK);
  localparam logic [CNT_W-1:0] C_END_ERR = CNT_W'(END_ERR);

  logic             busy_q, nack_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step, sample, at_ok_end, retry, start_new;

  assign step      = busy_q && tick_i;
  assign sample    = step && (cnt_q == C_SMP);
  assign at_ok_end = step && (cnt_q == C_END_OK) && !nack_q;
  assign retry     = step && (cnt_q == C_END_ERR);
  assign start_new = tick_i && tx_en_i && pend_i && (!busy_q || at_ok_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      nack_q <= 1'b0;
      cnt_q  <= '0;
    end else if (retry || start_new) begin
      busy_q <= 1'b1;
      nack_q <= 1'b0;
      cnt_q  <= '0;
    end else if (at_ok_end) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (sample && !io_i) nack_q <= 1'b1;
    end
  end

  assign load_o    = start_new;
  assign busy_o    = busy_q;
  assign cnt_o     = cnt_q;
  assign err_det_o = sample && !io_i;
  assign ok_det_o  = sample && io_i;
endmodule

// File: rtl/sc_t0_drv.sv
module sc_t0_drv #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned FR_W  = DATA_W + 2,
  localparam int unsigned EXT_W = 2 ** CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              oe_o
);
  logic [DATA_W-1:0] par_chain;
  logic [FR_W-1:0]   frame_q;
  logic [EXT_W-1:0]  frame_ext;

  // even parity as an XOR chain
  assign par_chain[0] = data_i[0];
  for (genvar i = 1; i < DATA_W; i++) begin : g_par
    assign par_chain[i] = par_chain[i-1] ^ data_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '1;
    else if (load_i) frame_q <= {par_chain[DATA_W-1], data_i, 1'b0};
  end

  // units past parity read as 1 -> released
  assign frame_ext = {{(EXT_W - FR_W){1'b1}}, frame_q};
  assign oe_o      = busy_i && !frame_ext[cnt_i];
endmodule

// File: rtl/sc_t0_flags.sv
module sc_t0_flags
  import sc_t0_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              err_det_i,
  input  logic              ok_det_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] tdr_o,
  output sc_t0_stat_t       stat_o
);
  logic [DATA_W-1:0] tdr_q;
  sc_t0_stat_t       st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdr_q <= '0;
      st_q  <= '{tdre: 1'b1, tend: 1'b1, err: 1'b0};
    end else begin
      if (wr_en_i) tdr_q <= wr_data_i;
      // a fresh write wins over same-cycle set events
      if (wr_en_i)     st_q.tdre <= 1'b0;
      else if (load_i) st_q.tdre <= 1'b1;
      if (wr_en_i)       st_q.tend <= 1'b0;
      else if (ok_det_i) st_q.tend <= 1'b1;
      if (err_det_i)      st_q.err <= 1'b1;
      else if (err_clr_i) st_q.err <= 1'b0;
    end
  end

  assign tdr_o  = tdr_q;
  assign stat_o = st_q;
endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
  import sc_t0_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1 + GAP_ERR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              etu_tick_i,
  input  logic              tx_en_i,
  input  logic              rie_i,
  input  logic              tie_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              err_clr_i,
  input  logic              io_i,
  output logic              io_oe_o,
  output logic              tdre_o,
  output logic              tend_o,
  output logic              err_o,
  output logic              irq_err_o,
  output logic              irq_tend_o
);
  logic              load, busy, err_det, ok_det;
  logic [CNT_W-1:0]  frame_cnt;
  logic [DATA_W-1:0] tdr;
  sc_t0_stat_t       stat;

  sc_t0_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (etu_tick_i),
    .tx_en_i   (tx_en_i),
    .pend_i    (!stat.tdre),
    .io_i      (io_i),
    .load_o    (load),
    .busy_o    (busy),
    .cnt_o     (frame_cnt),
    .err_det_o (err_det),
    .ok_det_o  (ok_det)
  );

  sc_t0_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .err_det_i (err_det),
    .ok_det_i  (ok_det),
    .err_clr_i (err_clr_i),
    .tdr_o     (tdr),
    .stat_o    (stat)
  );

  sc_t0_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (tdr),
    .busy_i (busy),
    .cnt_i  (frame_cnt),
    .oe_o   (io_oe_o)
  );

  assign tdre_o     = stat.tdre;
  assign tend_o     = stat.tend;
  assign err_o      = stat.err;
  assign irq_err_o  = stat.err && rie_i;
  assign irq_tend_o = stat.tend && tie_i;
endmodule

// File: rtl/sc_t0_tx_chk.sv
module sc_t0_tx_chk
  import sc_t0_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             etu_tick_i,
  input logic             io_i,
  input logic             io_oe_o,
  input logic             tdre_o,
  input logic             tend_o,
  input logic             err_o,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] C_PAR = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] C_SMP = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] C_ERR = CNT_W'(DATA_W + 1 + GAP_ERR);

  a_r1_unit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !etu_tick_i |=> ($stable(cnt) && $stable(busy)));

  a_r2_drive_in_bits_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> (busy && cnt <= C_PAR));

  a_r3_empty_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdre_o) |-> (busy && cnt == '0));

  a_r4_err_from_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(etu_tick_i && busy && cnt == C_SMP && !io_i));

  a_r6_resend_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (etu_tick_i && busy && cnt == C_ERR) |=> (busy && cnt == '0));

  a_r7_tend_from_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_o) |-> $past(etu_tick_i && busy && cnt == C_SMP && io_i));
endmodule

bind sc_t0_tx sc_t0_tx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .etu_tick_i (etu_tick_i),
  .io_i       (io_i),
  .io_oe_o    (io_oe_o),
  .tdre_o     (tdre_o),
  .tend_o     (tend_o),
  .err_o      (err_o),
  .busy       (busy),
  .cnt        (frame_cnt)
);

// File: tb/sc_t0_tx_test.sv
module sc_t0_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, tx_en = 1'b1, rie = 1'b0, tie = 1'b0;
  logic wr_en = 1'b0, err_clr = 1'b0, card_nack = 1'b0;
  logic [7:0] wr_data = '0;
  logic io_oe, tdre, tend, err, irq_err, irq_tend;
  logic io_line;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign io_line = !(io_oe || card_nack);

  sc_t0_tx uut (
    .clk_i (clk), .rst_ni (rst_n), .etu_tick_i (tick), .tx_en_i (tx_en),
    .rie_i (rie), .tie_i (tie), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .err_clr_i (err_clr), .io_i (io_line), .io_oe_o (io_oe), .tdre_o (tdre),
    .tend_o (tend), .err_o (err), .irq_err_o (irq_err), .irq_tend_o (irq_tend)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  // runs units 0..10 of a character, ending right after the sampling tick
  task automatic run_frame(input logic [7:0] b, input bit nack, input string req);
    logic [9:0] exp_bits = {^b, b, 1'b0};
    logic [9:0] got;
    logic tdre_at_load;
    for (int u = 0; u < 10; u++) begin
      tick_once();
      got[u] = io_line;
      if (u == 0) tdre_at_load = tdre;
    end
    check({req, " R1 bits"}, int'(got), int'(exp_bits));
    check("R3 tdre set at start", int'(tdre_at_load), 1);
    tick_once();
    check("R2 released in error window", int'(io_oe), 0);
    card_nack = nack;
    tick_once();
    card_nack = 1'b0;
  endtask

  task automatic test_reset();
    check("R10 tdre", int'(tdre), 1);
    check("R10 tend", int'(tend), 1);
    check("R10 err", int'(err), 0);
    check("R10 oe", int'(io_oe), 0);
  endtask

  task automatic test_clean();
    tie = 1'b1;
    write_byte(8'hA5);
    check("R3 tdre cleared by write", int'(tdre), 0);
    check("R3 tend cleared by write", int'(tend), 0);
    run_frame(8'hA5, 1'b0, "clean A5");
    check("R7 tend on clean sample", int'(tend), 1);
    check("R8 irq_tend with tie", int'(irq_tend), 1);
    check("R4 err clear without nack", int'(err), 0);
    for (int k = 0; k < 4; k++) begin
      tick_once();
      check("R7 idle when nothing pending", int'(io_oe), 0);
    end
  endtask

  task automatic test_retry();
    rie = 1'b1;
    write_byte(8'h3C);
    run_frame(8'h3C, 1'b1, "nacked 3C");
    check("R4 err on nack", int'(err), 1);
    check("R5 irq_err with rie", int'(irq_err), 1);
    check("R6 tend withheld", int'(tend), 0);
    tick_once();
    check("R6 third gap unit released", int'(io_oe), 0);
    clear_err();
    check("R4 err cleared by write 0", int'(err), 0);
    check("R5 irq_err drops", int'(irq_err), 0);
    run_frame(8'h3C, 1'b0, "R6 resend 3C");
    check("R7 tend after resend", int'(tend), 1);
    rie = 1'b0;
  endtask

  task automatic test_masks();
    tie = 1'b0;
    write_byte(8'h80);
    run_frame(8'h80, 1'b1, "nacked 80");
    check("R5 irq_err masked", int'(irq_err), 0);
    check("R4 err set", int'(err), 1);
    tick_once();
    run_frame(8'h80, 1'b1, "R6 second nack 80");
    check("R6 tend still 0", int'(tend), 0);
    tick_once();
    run_frame(8'h80, 1'b0, "R6 final 80");
    check("R4 err sticky without clear", int'(err), 1);
    check("R7 tend set", int'(tend), 1);
    check("R8 irq_tend masked", int'(irq_tend), 0);
    clear_err();
  endtask

  task automatic test_back_to_back();
    write_byte(8'h01);
    run_frame(8'h01, 1'b0, "first 01");
    check("R7 tend after first", int'(tend), 1);
    write_byte(8'hFE);
    check("R3 tend cleared by next write", int'(tend), 0);
    run_frame(8'hFE, 1'b0, "R7 two-unit gap FE");
    check("R7 tend after second", int'(tend), 1);
  endtask

  task automatic test_enable();
    tx_en = 1'b0;
    write_byte(8'h5A);
    for (int k = 0; k < 4; k++) begin
      tick_once();
      check("R9 no start when disabled", int'(io_oe), 0);
    end
    check("R9 byte stays pending", int'(tdre), 0);
    tx_en = 1'b1;
    run_frame(8'h5A, 1'b0, "R9 after enable 5A");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_clean();
    test_retry();
    test_masks();
    test_back_to_back();
    test_enable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule